// File: doc/BRIEF.md
# Control Register Bank with Set, Clear and Toggle Aliases

This block is a bank of 32-bit control registers that sits behind a simple single-port bus: one byte address, a read strobe, a write strobe, a size code and 32-bit write data, with registered read data. The decoded window spans 0x5000 bytes. The low part of the window holds plain registers that are rewritten whole on every write. A second region starts at byte offset 0x4000 and holds registers that each occupy four consecutive words: the register itself, then a set word, a clear word and a toggle word.

A write to one of those three extra words changes only the bits named in the write data, in a single cycle. Software can therefore flip one field without a read-modify-write sequence. A read of any of the three extra words returns the register they belong to. Every register has its own reset constant. Registers that control a frequency synthesiser also have a lock-status bit that is forced high at reset.

Top module: `stcbank_top`

## Requirements
- R1: After reset the plain registers at byte offsets 0x00..0x1C read 0x040116FF, 0x00018D40, 0x00022324, 0xFFFFFFFF, 0xFFFFFFFF, 0xFC3FFFFF, 0xFFFFFFFF and 0x00000000, in that order.
- R2: After reset the aliased registers at 0x4000, 0x4010, 0x4020 and 0x4030 read 0x80013042, 0x80013001, 0x1018101B and 0x00000000. The first two are synthesiser controls, whose lock bit (bit 31) is forced to 1 on top of their reset constant.
- R3: A legal write to a plain register, or to the first word of an aliased register, replaces all 32 bits with the write data.
- R4: A write to the word at base+4 of an aliased register ORs the write data into that register.
- R5: A write to the word at base+8 of an aliased register clears every register bit that is 1 in the write data.
- R6: A write to the word at base+0xC of an aliased register inverts every register bit that is 1 in the write data.
- R7: A read of base+4, base+8 or base+0xC returns the current value of the aliased register at base.
- R8: Read data appears on the cycle after the read strobe. It then holds until the next read strobe.
- R9: When the read and write strobes are both high in one cycle, the read returns the register value from before that write.
- R10: A read of an unmapped address returns zero and a write to it changes no register. Unmapped addresses are 0x20..0x3FFC, aliased slots beyond the fourth register (0x4040..0x4FFC), and anything at or above 0x5000.
- R11: An access is legal only with size code 2 (32-bit) and address bits [1:0] equal to 0. Any other access returns zero when read and changes nothing when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 15 | Byte address inside the window |
| busSize | input | 2 | Access size code; 2 means a 32-bit access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |

## Verification
A single address drives both the read and the write, so a read and a modify of the same register can fall in one cycle. This applies to a plain write as well as to a set, clear or toggle of an aliased register. The bench raises both strobes together on plain words, on base words and on alias words. It expects the returned word to be the value before the change, and the following read to show the change. A behavioural model of the register contents predicts the read data every cycle, across both directed sequences and a long run of mixed random accesses that includes illegal sizes, misaligned addresses and holes in the map.

// File: rtl/stcbank_pkg.sv
package stcbank_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 8;
  localparam logic [1:0]  SIZE_WORD = 2'd2;

  // Position of a word within an aliased register's four-word slot.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } aliasOp_e;

  // Strobes from the decoder to the storage.
  typedef struct packed {
    logic             wrPlain;
    logic             wrAlias;
    logic             rdEn;
    logic             rdHit;
    logic             rdAlias;
    logic [IDX_W-1:0] plainIdx;
    logic [IDX_W-1:0] aliasIdx;
    aliasOp_e         op;
  } bankStrobe_t;

endpackage

// File: rtl/stcbank_ctrl.sv
module stcbank_ctrl
  import stcbank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned WINDOW_BYTES = 32'h5000,
  parameter int unsigned ALIAS_BASE   = 32'h4000,
  parameter int unsigned PLAIN_WORDS  = 8,
  parameter int unsigned ALIAS_REGS   = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output bankStrobe_t       strobe
);

  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned RNUM_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] aliasBaseA = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] windowEndA = ADDR_W'(WINDOW_BYTES);
  localparam logic [WIDX_W-1:0] aliasBaseW = WIDX_W'(ALIAS_BASE / 4);

  logic              legal;
  logic [WIDX_W-1:0] wordIdx;
  logic [WIDX_W-1:0] aliasWordRel;
  logic [RNUM_W-1:0] regNum;
  logic              plainHit;
  logic              aliasSpan;
  logic              aliasHit;

  always_comb begin
    legal        = (busSize == SIZE_WORD) && (busAddr[1:0] == 2'b00);
    wordIdx      = busAddr[ADDR_W-1:2];
    aliasWordRel = wordIdx - aliasBaseW;
    regNum       = aliasWordRel[WIDX_W-1:2];
    plainHit     = legal && (wordIdx < WIDX_W'(PLAIN_WORDS));
    aliasSpan    = legal && (busAddr >= aliasBaseA) && (busAddr < windowEndA);
    aliasHit     = aliasSpan && (regNum < RNUM_W'(ALIAS_REGS));
  end

  always_comb begin
    strobe          = '0;
    strobe.rdEn     = busRdEn;
    strobe.rdHit    = busRdEn && (plainHit || aliasHit);
    strobe.rdAlias  = aliasHit;
    strobe.wrPlain  = busWrEn && plainHit;
    strobe.wrAlias  = busWrEn && aliasHit;
    strobe.plainIdx = IDX_W'(wordIdx);
    strobe.aliasIdx = IDX_W'(regNum);
    strobe.op       = aliasOp_e'(aliasWordRel[1:0]);
  end

endmodule

// File: rtl/stcbank_dp.sv
module stcbank_dp
  import stcbank_pkg::*;
#(
  parameter int unsigned PLAIN_WORDS = 8,
  parameter int unsigned ALIAS_REGS  = 4,
  parameter logic [PLAIN_WORDS*WORD_W-1:0] PLAIN_INIT = '0,
  parameter logic [ALIAS_REGS*WORD_W-1:0]  ALIAS_INIT = '0,
  parameter logic [ALIAS_REGS-1:0]         PLL_MASK   = '0,
  parameter int unsigned LOCK_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  bankStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);

  localparam logic [WORD_W-1:0] lockMask = WORD_W'(1) << LOCK_BIT;

  logic [WORD_W-1:0] plainQ [PLAIN_WORDS];
  logic [WORD_W-1:0] aliasQ [ALIAS_REGS];
  logic [WORD_W-1:0] rdNext;

  for (genvar i = 0; i < PLAIN_WORDS; i++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst) begin
        plainQ[i] <= PLAIN_INIT[i*WORD_W +: WORD_W];
      end else if (strobe.wrPlain && (strobe.plainIdx == IDX_W'(i))) begin
        plainQ[i] <= wrData;
      end
    end
  end

  for (genvar j = 0; j < ALIAS_REGS; j++) begin : g_alias
    localparam logic [WORD_W-1:0] initVal =
      ALIAS_INIT[j*WORD_W +: WORD_W] | (PLL_MASK[j] ? lockMask : '0);
    always_ff @(posedge clk) begin
      if (rst) begin
        aliasQ[j] <= initVal;
      end else if (strobe.wrAlias && (strobe.aliasIdx == IDX_W'(j))) begin
        unique case (strobe.op)
          OP_WRITE: aliasQ[j] <= wrData;
          OP_SET:   aliasQ[j] <= aliasQ[j] | wrData;
          OP_CLR:   aliasQ[j] <= aliasQ[j] & ~wrData;
          OP_TOG:   aliasQ[j] <= aliasQ[j] ^ wrData;
          default:  aliasQ[j] <= aliasQ[j];
        endcase
      end
    end
  end

  // Read selection uses the state before any same-cycle write.
  always_comb begin
    rdNext = '0;
    if (strobe.rdHit) begin
      if (strobe.rdAlias) begin
        for (int j = 0; j < ALIAS_REGS; j++) begin
          if (strobe.aliasIdx == IDX_W'(j)) rdNext = aliasQ[j];
        end
      end else begin
        for (int i = 0; i < PLAIN_WORDS; i++) begin
          if (strobe.plainIdx == IDX_W'(i)) rdNext = plainQ[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.rdEn) begin
      rdData <= rdNext;
    end
  end

endmodule

// File: rtl/stcbank_top.sv
module stcbank_top
  import stcbank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned WINDOW_BYTES = 32'h5000,
  parameter int unsigned ALIAS_BASE   = 32'h4000,
  parameter int unsigned PLAIN_WORDS  = 8,
  parameter int unsigned ALIAS_REGS   = 4,
  parameter logic [PLAIN_WORDS*WORD_W-1:0] PLAIN_INIT = {
    32'h00000000, 32'hFFFFFFFF, 32'hFC3FFFFF, 32'hFFFFFFFF,
    32'hFFFFFFFF, 32'h00022324, 32'h00018D40, 32'h040116FF },
  parameter logic [ALIAS_REGS*WORD_W-1:0] ALIAS_INIT = {
    32'h00000000, 32'h1018101B, 32'h00013001, 32'h00013042 },
  parameter logic [ALIAS_REGS-1:0] PLL_MASK = 4'b0011,
  parameter int unsigned LOCK_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData
);

  bankStrobe_t strobe;

  stcbank_ctrl #(
    .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES), .ALIAS_BASE(ALIAS_BASE),
    .PLAIN_WORDS(PLAIN_WORDS), .ALIAS_REGS(ALIAS_REGS)
  ) u_ctrl (
    .busAddr(busAddr), .busSize(busSize), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strobe(strobe)
  );

  stcbank_dp #(
    .PLAIN_WORDS(PLAIN_WORDS), .ALIAS_REGS(ALIAS_REGS),
    .PLAIN_INIT(PLAIN_INIT), .ALIAS_INIT(ALIAS_INIT),
    .PLL_MASK(PLL_MASK), .LOCK_BIT(LOCK_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wrData(busWrData), .rdData(busRdData)
  );

endmodule

// File: rtl/stcbank_chk.sv
module stcbank_chk #(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned WINDOW_BYTES = 32'h5000,
  parameter int unsigned ALIAS_BASE   = 32'h4000,
  parameter int unsigned PLAIN_WORDS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busRdEn,
  input logic [31:0]       busRdData
);

  localparam logic [ADDR_W-1:0] windowEndA = ADDR_W'(WINDOW_BYTES);
  localparam logic [ADDR_W-1:0] aliasBaseA = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] plainEndA  = ADDR_W'(PLAIN_WORDS * 4);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busRdEn |=> $stable(busRdData));

  // R11
  size_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busSize != 2'd2) |=> (busRdData == 32'h0));

  // R11
  misalign_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr[1:0] != 2'b00) |=> (busRdData == 32'h0));

  // R10
  outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr >= windowEndA) |=> (busRdData == 32'h0));

  // R10
  gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr >= plainEndA && busAddr < aliasBaseA) |=> (busRdData == 32'h0));

endmodule

bind stcbank_top stcbank_chk #(
  .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES),
  .ALIAS_BASE(ALIAS_BASE), .PLAIN_WORDS(PLAIN_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busSize(busSize),
  .busRdEn(busRdEn), .busRdData(busRdData)
);

// File: tb/stcbank_top_tb.sv
`timescale 1ns/1ps
module stcbank_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] plainM [8];
  logic [31:0] aliasM [4];
  logic [31:0] expRd;

  always #4 clk = ~clk;

  stcbank_top u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busSize(busSize),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData)
  );

  function automatic bit isLegal(int unsigned a, int unsigned sz);
    return (sz == 2) && ((a % 4) == 0);
  endfunction

  function automatic logic [31:0] modelRead(int unsigned a, int unsigned sz);
    if (!isLegal(a, sz)) return 32'h0;
    if (a < 32) return plainM[a / 4];
    if (a >= 32'h4000 && a < 32'h5000 && ((a - 32'h4000) / 16) < 4)
      return aliasM[(a - 32'h4000) / 16];
    return 32'h0;
  endfunction

  task automatic modelWrite(int unsigned a, int unsigned sz, logic [31:0] d);
    int unsigned r;
    int unsigned k;
    if (!isLegal(a, sz)) return;
    if (a < 32) begin
      plainM[a / 4] = d;
    end else if (a >= 32'h4000 && a < 32'h5000) begin
      r = (a - 32'h4000) / 16;
      k = ((a - 32'h4000) / 4) % 4;
      if (r < 4) begin
        case (k)
          0: aliasM[r] = d;
          1: aliasM[r] = aliasM[r] | d;
          2: aliasM[r] = aliasM[r] & ~d;
          default: aliasM[r] = aliasM[r] ^ d;
        endcase
      end
    end
  endtask

  // One bus cycle: drive after a falling edge, judge at the next falling edge.
  task automatic step(bit we, bit re, int unsigned a, int unsigned sz,
                      logic [31:0] d, string tag);
    busWrEn   = we;
    busRdEn   = re;
    busAddr   = 15'(a);
    busSize   = 2'(sz);
    busWrData = d;
    if (re) expRd = modelRead(a, sz);
    if (we) modelWrite(a, sz, d);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (busRdData !== expRd) begin
      fails++;
      $display("FAIL %s addr=%h size=%0d we=%0b re=%0b: got %h expected %h",
               tag, a, sz, we, re, busRdData, expRd);
    end
  endtask

  task automatic rd(int unsigned a, string tag);
    step(1'b0, 1'b1, a, 2, 32'h0, tag);
  endtask

  task automatic wr(int unsigned a, logic [31:0] d, string tag);
    step(1'b1, 1'b0, a, 2, d, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    plainM[0] = 32'h040116FF; plainM[1] = 32'h00018D40;
    plainM[2] = 32'h00022324; plainM[3] = 32'hFFFFFFFF;
    plainM[4] = 32'hFFFFFFFF; plainM[5] = 32'hFC3FFFFF;
    plainM[6] = 32'hFFFFFFFF; plainM[7] = 32'h00000000;
    aliasM[0] = 32'h80013042; aliasM[1] = 32'h80013001;
    aliasM[2] = 32'h1018101B; aliasM[3] = 32'h00000000;
    expRd = 32'h0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0, 0, 2, 0, "R8 reset read data");

    // R1 / R2 reset values, R7 alias read-through
    for (int i = 0; i < 8; i++) rd(i * 4, "R1");
    for (int j = 0; j < 4; j++) rd(32'h4000 + j * 16, "R2");
    for (int j = 0; j < 4; j++)
      for (int k = 1; k < 4; k++) rd(32'h4000 + j * 16 + k * 4, "R7");

    // R3 whole-word replace
    wr(32'h0C, 32'h12345678, "R3");
    rd(32'h0C, "R3");
    wr(32'h4030, 32'hA5A5_0F0F, "R3");
    rd(32'h4030, "R3");

    // R4 / R5 / R6 alias modifies
    wr(32'h4014, 32'h0000_00F0, "R4");
    rd(32'h4010, "R4");
    wr(32'h4018, 32'h8000_0001, "R5");
    rd(32'h4010, "R5");
    wr(32'h400C, 32'hFFFF_0000, "R6");
    rd(32'h4000, "R6");
    rd(32'h4008, "R7");
    rd(32'h400C, "R7");

    // R8 hold across idle cycles
    repeat (3) step(1'b0, 1'b0, 32'h4000, 2, 32'h0, "R8");

    // R9 same-cycle read and write
    step(1'b1, 1'b1, 32'h08, 2, 32'hDEAD_BEEF, "R9");
    rd(32'h08, "R9");
    step(1'b1, 1'b1, 32'h4024, 2, 32'h0000_FF00, "R9");
    rd(32'h4020, "R9");
    step(1'b1, 1'b1, 32'h403C, 2, 32'hFFFF_FFFF, "R9");
    rd(32'h4030, "R9");

    // R10 unmapped addresses
    wr(32'h20, 32'h1111_1111, "R10");
    rd(32'h20, "R10");
    wr(32'h3FFC, 32'h2222_2222, "R10");
    rd(32'h3FFC, "R10");
    wr(32'h4040, 32'h3333_3333, "R10");
    wr(32'h4044, 32'h3333_3333, "R10");
    rd(32'h4040, "R10");
    wr(32'h5000, 32'h4444_4444, "R10");
    rd(32'h5000, "R10");
    rd(32'h7FFC, "R10");
    for (int i = 0; i < 8; i++) rd(i * 4, "R10 untouched");
    for (int j = 0; j < 4; j++) rd(32'h4000 + j * 16, "R10 untouched");

    // R11 illegal size or alignment
    step(1'b1, 1'b0, 32'h00, 1, 32'h0BAD_0BAD, "R11");
    rd(32'h00, "R11");
    step(1'b1, 1'b0, 32'h4005, 2, 32'hFFFF_FFFF, "R11");
    rd(32'h4000, "R11");
    step(1'b0, 1'b1, 32'h04, 0, 32'h0, "R11");
    step(1'b0, 1'b1, 32'h06, 2, 32'h0, "R11");
    step(1'b0, 1'b1, 32'h4010, 3, 32'h0, "R11");

    // Mixed traffic against the model (R3..R11)
    for (int n = 0; n < 2000; n++) begin
      int unsigned sel;
      int unsigned a;
      int unsigned sz;
      sel = $urandom % 8;
      case (sel)
        0, 1, 2: a = ($urandom % 10) * 4;
        3, 4, 5: a = 32'h4000 + ($urandom % 20) * 4;
        6:       a = $urandom % 32'h8000;
        default: a = 32'h4000 + ($urandom % 24) * 4 + (($urandom % 4 == 0) ? 1 : 0);
      endcase
      sz = (($urandom % 8) == 0) ? ($urandom % 4) : 2;
      step(1'(($urandom % 2)), 1'(($urandom % 3) != 0), a, sz, $urandom,
           "R3-mixed R9-mixed");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule